// File: doc/BRIEF.md
# Microword Decode Stage with Control Latch

This block is the second stage of a two-stage microcode sequencer. Each clock edge it captures the 24-bit microword that storage delivers for the current address. It then decodes the captured word into the bus control strobes for the rest of the processor. An executed word selects one data-bus driver, one data-bus receiver, one address-bus driver and one address-bus receiver. Each selection comes out as a one-hot strobe vector. The same word also drives six shared option lines. The three-bit condition select of every word is passed on to the sequencer, which uses it to pick the code plane of the next fetch.

A word with its disable flag set is not executed. It asserts no strobe and no option line. Its low 16 bits are presented as an immediate value. The word also always writes one bit into an eight-bit addressable control latch, on the edge after it enters the stage. The latch outputs select the clock prescaler, request halt, enable interrupts, light three status lamps and request a soft reset. Because this write cannot be suppressed, every immediate word must carry a harmless latch write, such as a zero to the soft-reset bit.

Data-bus unit 0 is the sequencer itself. Its driver strobe means "put the immediate value on the bus". Its receiver strobe means "load a new microcode address from the bus".

Top module: `ucd_stage`

## Requirements
- R1: `cond_sel` equals bits 23..21 of the captured word, for both word forms, from the edge that captures the word.
- R2: For an executed word (bit 20 = 0), `data_oe` has exactly one bit set, at the index given by bits 3..0. `data_ld` has exactly one bit set, at the index given by bits 7..4. Index 0 is the sequencer itself.
- R3: For an executed word, `addr_oe` has exactly one bit set, at the index given by bits 10..8. `addr_ld` has exactly one bit set, at the index given by bits 13..11.
- R4: For an executed word, `opt_out` equals bits 19..14. For a disabled word, `opt_out` is zero.
- R5: For a disabled word (bit 20 = 1), all four strobe vectors are zero and `imm_value` equals bits 15..0. For an executed word, `imm_value` is zero.
- R6: A disabled word in the stage writes bit 16 into the latch bit addressed by bits 19..17, at the next clock edge. All other latch bits keep their values.
- R7: An executed word leaves every latch bit unchanged.
- R8: The latch bits drive the outputs as follows: bit 0 `div2_en_n`, bit 1 `div4_en_n`, bit 2 `halt_req`, bit 3 `irq_en`, bit 4 `lamp_green`, bit 5 `lamp_yellow`, bit 6 `lamp_red`, bit 7 `soft_rst`.
- R9: While `rst_n` is low, the stage holds a disabled word with condition 0, latch address 7, latch data 0 and immediate 0. The latch is reset to 8'h03: both prescaler enables inactive, everything else off. As a result, all strobes read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uword_in | input | 24 | Microword read at the current address |
| cond_sel | output | 3 | Condition select of the staged word |
| data_oe | output | 16 | One-hot data-bus driver strobes |
| data_ld | output | 16 | One-hot data-bus load strobes |
| addr_oe | output | 8 | One-hot address-bus driver strobes |
| addr_ld | output | 8 | One-hot address-bus load strobes |
| opt_out | output | 6 | Shared option lines |
| imm_value | output | 16 | Immediate value of a disabled word |
| div2_en_n | output | 1 | Divide-by-2 prescaler enable, active low |
| div4_en_n | output | 1 | Divide-by-4 prescaler enable, active low |
| halt_req | output | 1 | Halt until interrupt |
| irq_en | output | 1 | Interrupt enable |
| lamp_green | output | 1 | Green status lamp |
| lamp_yellow | output | 1 | Yellow status lamp |
| lamp_red | output | 1 | Red status lamp |
| soft_rst | output | 1 | Soft reset request |

## Verification
Faults in the staged word register show up at the strobe ports in the cycle after capture. A bad field slice appears as a strobe at the wrong index, as two strobes at once, or as a strobe during an immediate word. A latch fault has two visible forms. One is a control output that changes one edge too early or too late. The other is a neighbouring bit that flips together with the addressed bit. The bench therefore checks every latch output both before and after the write edge.

// File: rtl/ucd_pkg.sv
// Shared widths and word layouts for the microword decode stage.
// Assumes a 24-bit microword with the disable flag at bit 20.
package ucd_pkg;
    localparam int WORD_W   = 24;
    localparam int COND_W   = 3;
    localparam int OPT_W    = 6;
    localparam int ASEL_W   = 3;
    localparam int DSEL_W   = 4;
    localparam int IMM_W    = 16;
    localparam int LATCH_AW = 3;
    localparam int LATCH_N  = 1 << LATCH_AW;
    localparam int N_DUNIT  = 1 << DSEL_W;
    localparam int N_AUNIT  = 1 << ASEL_W;
    localparam int DIS_BIT  = 20;

    // Layout of an executed word
    typedef struct packed {
        logic [COND_W-1:0] cond;
        logic              dis;
        logic [OPT_W-1:0]  opt;
        logic [ASEL_W-1:0] a_tgt;
        logic [ASEL_W-1:0] a_src;
        logic [DSEL_W-1:0] d_tgt;
        logic [DSEL_W-1:0] d_src;
    } exec_word_t;

    // Layout of an immediate (disabled) word
    typedef struct packed {
        logic [COND_W-1:0]   cond;
        logic                dis;
        logic [LATCH_AW-1:0] l_addr;
        logic                l_data;
        logic [IMM_W-1:0]    imm;
    } imm_word_t;
endpackage

// File: rtl/ucd_onehot.sv
// Enabled binary-to-one-hot decoder.
// Assumes nothing about the select value; all outputs are low when en is low.
module ucd_onehot #(
    parameter int SEL_W = 4,
    localparam int N    = 1 << SEL_W
) (
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic [N-1:0]     y
);
    // One comparator per output line
    for (genvar i = 0; i < N; i++) begin : g_line
        assign y[i] = en && (sel == SEL_W'(i));
    end
endmodule

// File: rtl/ucd_ctl_latch.sv
// Eight-bit (by default) addressable control latch: one bit is written per enabled edge.
// Assumes synchronous active-low reset to INIT; reset wins over a write.
module ucd_ctl_latch #(
    parameter int AW = 3,
    localparam int N = 1 << AW,
    parameter logic [N-1:0] INIT = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wdata,
    output logic [N-1:0]  q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Store one latch bit; update only when this bit is addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= INIT[i];
            else if (we && (waddr == AW'(i)))
                q[i] <= wdata;
        end
    end
endmodule

// File: rtl/ucd_stage.sv
// Microword decode stage: captures the microword, expands its fields into
// one-hot bus strobes and option lines, and applies the latch write carried
// by disabled (immediate) words one edge later.
// Assumes the storage delivers a stable word before each rising edge.
module ucd_stage
    import ucd_pkg::*;
#(
    parameter logic [WORD_W-1:0]  RST_WORD   = 24'h1E0000,
    parameter logic [LATCH_N-1:0] LATCH_INIT = 8'h03
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  uword_in,
    output logic [COND_W-1:0]  cond_sel,
    output logic [N_DUNIT-1:0] data_oe,
    output logic [N_DUNIT-1:0] data_ld,
    output logic [N_AUNIT-1:0] addr_oe,
    output logic [N_AUNIT-1:0] addr_ld,
    output logic [OPT_W-1:0]   opt_out,
    output logic [IMM_W-1:0]   imm_value,
    output logic               div2_en_n,
    output logic               div4_en_n,
    output logic               halt_req,
    output logic               irq_en,
    output logic               lamp_green,
    output logic               lamp_yellow,
    output logic               lamp_red,
    output logic               soft_rst
);
    logic [WORD_W-1:0]  word_q;
    exec_word_t         xw;
    imm_word_t          iw;
    logic               exec_en;
    logic [LATCH_N-1:0] latch_q;

    // Capture the microword read at the current address
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= RST_WORD;
        else
            word_q <= uword_in;
    end

    assign xw      = exec_word_t'(word_q);
    assign iw      = imm_word_t'(word_q);
    assign exec_en = !xw.dis;

    // Fields shared by both forms, and those gated by the word form
    always_comb begin
        cond_sel  = xw.cond;
        opt_out   = exec_en ? xw.opt : '0;
        imm_value = exec_en ? '0 : iw.imm;
    end

    ucd_onehot #(.SEL_W(DSEL_W)) u_dsrc (.en(exec_en), .sel(xw.d_src), .y(data_oe));
    ucd_onehot #(.SEL_W(DSEL_W)) u_dtgt (.en(exec_en), .sel(xw.d_tgt), .y(data_ld));
    ucd_onehot #(.SEL_W(ASEL_W)) u_asrc (.en(exec_en), .sel(xw.a_src), .y(addr_oe));
    ucd_onehot #(.SEL_W(ASEL_W)) u_atgt (.en(exec_en), .sel(xw.a_tgt), .y(addr_ld));

    ucd_ctl_latch #(.AW(LATCH_AW), .INIT(LATCH_INIT)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (iw.dis),
        .waddr (iw.l_addr),
        .wdata (iw.l_data),
        .q     (latch_q)
    );

    // Map latch bits to the control outputs
    always_comb begin
        div2_en_n   = latch_q[0];
        div4_en_n   = latch_q[1];
        halt_req    = latch_q[2];
        irq_en      = latch_q[3];
        lamp_green  = latch_q[4];
        lamp_yellow = latch_q[5];
        lamp_red    = latch_q[6];
        soft_rst    = latch_q[7];
    end
endmodule

// File: rtl/ucd_checker.sv
// Property checker for ucd_stage, attached through bind.
module ucd_checker
    import ucd_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [WORD_W-1:0]  word_q,
    input logic [LATCH_N-1:0] latch_q,
    input logic [N_DUNIT-1:0] data_oe,
    input logic [N_DUNIT-1:0] data_ld,
    input logic [N_AUNIT-1:0] addr_oe,
    input logic [N_AUNIT-1:0] addr_ld,
    input logic [OPT_W-1:0]   opt_out
);
    // R2: one data driver and one data receiver per executed word
    a_r2_data_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        !word_q[DIS_BIT] |-> ($onehot(data_oe) && $onehot(data_ld)));

    // R3: one address driver and one address receiver per executed word
    a_r3_addr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        !word_q[DIS_BIT] |-> ($onehot(addr_oe) && $onehot(addr_ld)));

    // R5: a disabled word is silent on every strobe and option line
    a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        word_q[DIS_BIT] |-> (data_oe == '0 && data_ld == '0 &&
                             addr_oe == '0 && addr_ld == '0 && opt_out == '0));

    // R6: the addressed latch bit takes the data bit one edge later
    a_r6_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(word_q[DIS_BIT]) |-> (latch_q[$past(word_q[19:17])] == $past(word_q[16])));

    // R7: an executed word leaves the latch alone
    a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(word_q[DIS_BIT]) |-> (latch_q == $past(latch_q)));
endmodule

bind ucd_stage ucd_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .word_q  (word_q),
    .latch_q (latch_q),
    .data_oe (data_oe),
    .data_ld (data_ld),
    .addr_oe (addr_oe),
    .addr_ld (addr_ld),
    .opt_out (opt_out)
);

// File: tb/ucd_stage_test.sv
module ucd_stage_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] uword_in = 24'h0;
    logic [2:0]  cond_sel;
    logic [15:0] data_oe, data_ld, imm_value;
    logic [7:0]  addr_oe, addr_ld;
    logic [5:0]  opt_out;
    logic        div2_en_n, div4_en_n, halt_req, irq_en;
    logic        lamp_green, lamp_yellow, lamp_red, soft_rst;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] exp_latch;

    always #4 clk = ~clk;

    ucd_stage uut (
        .clk(clk), .rst_n(rst_n), .uword_in(uword_in), .cond_sel(cond_sel),
        .data_oe(data_oe), .data_ld(data_ld), .addr_oe(addr_oe), .addr_ld(addr_ld),
        .opt_out(opt_out), .imm_value(imm_value),
        .div2_en_n(div2_en_n), .div4_en_n(div4_en_n), .halt_req(halt_req), .irq_en(irq_en),
        .lamp_green(lamp_green), .lamp_yellow(lamp_yellow), .lamp_red(lamp_red),
        .soft_rst(soft_rst)
    );

    // Vector table: word, cond, data_oe, data_ld, addr_oe, addr_ld, opt, imm
    localparam int NV = 5;
    localparam logic [23:0] V_W   [NV] = '{24'hACEA93, 24'h000000, 24'h0FFFFF, 24'hF0BEEF, 24'h212345};
    localparam logic [2:0]  V_C   [NV] = '{3'd5, 3'd0, 3'd0, 3'd7, 3'd1};
    localparam logic [15:0] V_DOE [NV] = '{16'h0008, 16'h0001, 16'h8000, 16'h0000, 16'h0020};
    localparam logic [15:0] V_DLD [NV] = '{16'h0200, 16'h0001, 16'h8000, 16'h0000, 16'h0010};
    localparam logic [7:0]  V_AOE [NV] = '{8'h04, 8'h01, 8'h80, 8'h00, 8'h08};
    localparam logic [7:0]  V_ALD [NV] = '{8'h20, 8'h01, 8'h80, 8'h00, 8'h10};
    localparam logic [5:0]  V_OPT [NV] = '{6'h33, 6'h00, 6'h3F, 6'h00, 6'h04};
    localparam logic [15:0] V_IMM [NV] = '{16'h0000, 16'h0000, 16'h0000, 16'hBEEF, 16'h0000};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present a word and wait until it sits in the stage
    task automatic apply(input logic [23:0] w);
        @(negedge clk);
        uword_in = w;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] latch_now();
        return {soft_rst, lamp_red, lamp_yellow, lamp_green, irq_en, halt_req, div4_en_n, div2_en_n};
    endfunction

    // Disabled word: cond 0, bit20 set, address 19..17, data bit 16
    function automatic logic [23:0] lw(input int a, input logic d, input logic [15:0] imm);
        return {3'b000, 1'b1, 3'(a), d, imm};
    endfunction

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        check("R9 strobes", {data_oe, data_ld}, 32'h0);
        check("R9 addr strobes", {addr_oe, addr_ld}, 32'h0);
        check("R9 latch", latch_now(), 8'h03);
        check("R9 imm/cond", {imm_value, 13'h0, cond_sel}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        uword_in = 24'h000000;
        @(posedge clk);
        #1;
        check("R9 first write soft_rst 0", latch_now(), 8'h03);

        // Table walk: R1 R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            apply(V_W[i]);
            check("R1 cond", 32'(cond_sel), 32'(V_C[i]));
            check("R2 data_oe", 32'(data_oe), 32'(V_DOE[i]));
            check("R2 data_ld", 32'(data_ld), 32'(V_DLD[i]));
            check("R3 addr_oe", 32'(addr_oe), 32'(V_AOE[i]));
            check("R3 addr_ld", 32'(addr_ld), 32'(V_ALD[i]));
            check("R4 opt", 32'(opt_out), 32'(V_OPT[i]));
            check("R5 imm", 32'(imm_value), 32'(V_IMM[i]));
        end
        // Vector 3 wrote 0 to latch bit 0 on the edge that captured vector 4
        exp_latch = 8'h02;
        check("R6 table side write", latch_now(), exp_latch);

        // R6 R8: set each bit, one at a time, timing checked before and after the edge
        for (int a = 0; a < 8; a++) begin
            apply(lw(a, 1'b1, 16'h1234));
            check("R6 not yet written", latch_now(), exp_latch);
            exp_latch[a] = 1'b1;
            apply(24'h0ACE11);
            check("R6 R8 set bit", latch_now(), exp_latch);
        end
        // R7: executed words with busy fields keep the latch
        apply(24'h0FFFFF);
        apply(24'hEFFFFF);
        check("R7 hold", latch_now(), 8'hFF);
        // R6: clear alternate bits with back-to-back disabled words
        for (int a = 0; a < 8; a += 2) begin
            apply(lw(a, 1'b0, 16'hFFFF));
            check("R5 imm with latch write", 32'(imm_value), 32'h0000FFFF);
        end
        apply(24'h000000);
        check("R6 R8 clear even bits", latch_now(), 8'hAA);
        // Harmless immediate: address 7, data 0
        apply(lw(7, 1'b0, 16'h5A5A));
        apply(24'h000000);
        check("R8 soft_rst cleared", 32'(soft_rst), 32'h0);
        check("R6 neighbours kept", latch_now(), 8'h2A);

        // R9: reset again restores latch
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R9 latch after reset", latch_now(), 8'h03);
        check("R9 no strobes", {data_oe, data_ld}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule